// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles a branch-if-equal while the branch sits in the decode stage. A dedicated equality comparator works on the two register operands, so the result does not wait for the execute-stage ALU. The fetch side always assumes a branch falls through and keeps fetching the next sequential word. When the comparison shows the branch is taken, the block does two things on the same clock edge. It points the program counter at the branch target, and it turns the one wrongly fetched instruction in the fetch/decode register into a no-op with its valid bit cleared. A taken branch therefore costs one bubble, and a branch that falls through costs no cycles.

The block owns the program counter and the fetch/decode pipeline register. The instruction memory, the decoder, the register file and the hazard unit are outside it. The decoder reports whether the instruction held in the fetch/decode register is a branch and supplies its operands and offset. The hazard unit raises a stall when a branch operand is still being produced by the instruction just ahead of it. While that stall is high, the branch stays in decode and is not resolved.

Top module: `id_branch_resolver`

## Requirements
- R1: While reset is asserted, and for the synchronizer delay after it is released, `pc` equals `RESET_PC` (default 0), `ifid_valid` is 0, `ifid_instr` is the no-op word 32'h0000_0000, and both `pc_sel` and `ifid_flush` are 0.
- R2: With no stall and no redirect, each rising edge adds 4 to `pc`, and the fetch/decode register captures `if_instr` together with the address it was fetched from, with `ifid_valid` set to 1.
- R3: When `ifid_valid` is 1, `id_is_branch` is 1 and `id_hazard_stall` is 0, `pc_sel` and `ifid_flush` go to 1 in the same cycle exactly when all 32 bits of `id_opa` and `id_opb` are equal. Otherwise both stay 0.
- R4: `br_target` equals `ifid_pc + 4 + (sign-extended id_offset << 2)`. `id_offset` counts 32-bit instructions and may be negative.
- R5: A taken branch loads `br_target` into `pc` at the next edge. At that same edge the fetch/decode register becomes the no-op word with `ifid_valid` 0, which is a single bubble.
- R6: A branch that is not taken causes no flush. `pc` advances by 4, and the sequentially fetched instruction enters decode with `ifid_valid` 1.
- R7: While `id_hazard_stall` is 1, `pc`, `ifid_valid`, `ifid_instr` and `ifid_pc` hold their values, and `pc_sel` and `ifid_flush` stay 0 whatever the operands are.
- R8: While `ifid_valid` is 0, `id_is_branch` has no effect. No flush and no redirect happen, and `pc` advances by 4.
- R9: A branch held by a stall is resolved in the first cycle in which `id_hazard_stall` is 0. It is redirected only once, and there is no bubble beyond the single flushed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| if_instr | input | 32 | Instruction word read from instruction memory at `pc` |
| id_is_branch | input | 1 | Decoder flag: the instruction in decode is a branch-if-equal |
| id_opa | input | XLEN | First register operand of the branch |
| id_opb | input | XLEN | Second register operand of the branch |
| id_offset | input | OFF_W | Signed branch offset, counted in instructions |
| id_hazard_stall | input | 1 | Hazard unit request to hold fetch and decode for one cycle |
| pc | output | XLEN | Fetch address |
| pc_sel | output | 1 | Next-PC select: 0 sequential, 1 branch target |
| br_target | output | XLEN | Computed branch target address |
| ifid_flush | output | 1 | Flush of the fetch/decode register this cycle |
| ifid_valid | output | 1 | Valid bit of the fetch/decode register |
| ifid_instr | output | 32 | Instruction held in the fetch/decode register |
| ifid_pc | output | XLEN | Address of the instruction held in the fetch/decode register |

## Verification
Two functions can meet in one cycle: the release of a hazard stall and the resolution of the branch that the stall was holding. The bench holds a taken branch in decode under a stall for two cycles, with equal operands present throughout. It then drops the stall. The scoreboard expects no redirect while the stall is high. It expects exactly one redirect, to the target computed from the held instruction's address, in the release cycle. After that it expects a single bubble, followed by the target instruction.

// File: rtl/id_br_pkg.sv
package id_br_pkg;

  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned INSTR_SH = 2;   // log2 of the instruction size in bytes
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_BRANCH = 1'b1
  } pc_src_e;

  typedef struct packed {
    logic               valid;
    logic [INSTR_W-1:0] instr;
  } ifid_slot_t;

endpackage

// File: rtl/idbr_rst_sync.sv
module idbr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/idbr_eq_cmp.sv
module idbr_eq_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);

  logic [W-1:0] bit_same;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_same[i] = ~(a[i] ^ b[i]);
  end

  assign eq = &bit_same;

endmodule

// File: rtl/idbr_target_gen.sv
module idbr_target_gen
  import id_br_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  base_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);

  localparam int unsigned EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << INSTR_SH;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] off_bytes;

  assign off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign off_bytes = off_ext << INSTR_SH;
  assign target    = base_pc + STEP + off_bytes;

endmodule

// File: rtl/idbr_fetch_regs.sv
module idbr_fetch_regs
  import id_br_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  pc_src_e            pc_src,
  input  logic [XLEN-1:0]    target,
  input  logic [INSTR_W-1:0] if_instr,
  output logic [XLEN-1:0]    pc,
  output ifid_slot_t         slot,
  output logic [XLEN-1:0]    slot_pc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(1) << INSTR_SH;

  logic [XLEN-1:0] pc_q, pc_d;
  ifid_slot_t      slot_q, slot_d;
  logic [XLEN-1:0] spc_q, spc_d;

  always_comb begin
    pc_d   = pc_q;
    slot_d = slot_q;
    spc_d  = spc_q;
    if (advance) begin
      spc_d = pc_q;
      if (pc_src == PC_BRANCH) begin
        pc_d         = target;
        slot_d.valid = 1'b0;
        slot_d.instr = NOP_WORD;
      end else begin
        pc_d         = pc_q + STEP;
        slot_d.valid = 1'b1;
        slot_d.instr = if_instr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= RESET_PC;
      slot_q.valid <= 1'b0;
      slot_q.instr <= NOP_WORD;
      spc_q        <= RESET_PC;
    end else if (advance) begin
      pc_q   <= pc_d;
      slot_q <= slot_d;
      spc_q  <= spc_d;
    end
  end

  assign pc      = pc_q;
  assign slot    = slot_q;
  assign slot_pc = spc_q;

endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import id_br_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OFF_W    = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] if_instr,
  input  logic               id_is_branch,
  input  logic [XLEN-1:0]    id_opa,
  input  logic [XLEN-1:0]    id_opb,
  input  logic [OFF_W-1:0]   id_offset,
  input  logic               id_hazard_stall,
  output logic [XLEN-1:0]    pc,
  output logic               pc_sel,
  output logic [XLEN-1:0]    br_target,
  output logic               ifid_flush,
  output logic               ifid_valid,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [XLEN-1:0]    ifid_pc
);

  logic       rst_sync_n;
  logic       ops_equal;
  logic       resolve_now;
  logic       take;
  pc_src_e    pc_src;
  ifid_slot_t slot;

  idbr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  idbr_eq_cmp #(.W(XLEN)) u_cmp (
    .a  (id_opa),
    .b  (id_opb),
    .eq (ops_equal)
  );

  idbr_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .base_pc (ifid_pc),
    .offset  (id_offset),
    .target  (br_target)
  );

  // A branch is only judged from a live decode slot with its operands ready.
  assign resolve_now = slot.valid & id_is_branch & ~id_hazard_stall;
  assign take        = resolve_now & ops_equal;
  assign pc_src      = take ? PC_BRANCH : PC_SEQ;

  idbr_fetch_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .advance  (~id_hazard_stall),
    .pc_src   (pc_src),
    .target   (br_target),
    .if_instr (if_instr),
    .pc       (pc),
    .slot     (slot),
    .slot_pc  (ifid_pc)
  );

  assign pc_sel     = (pc_src == PC_BRANCH);
  assign ifid_flush = take;
  assign ifid_valid = slot.valid;
  assign ifid_instr = slot.instr;

endmodule

// File: rtl/id_branch_resolver_chk.sv
module id_branch_resolver_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_hazard_stall,
  input logic [XLEN-1:0] pc,
  input logic            pc_sel,
  input logic [XLEN-1:0] br_target,
  input logic            ifid_flush,
  input logic            ifid_valid,
  input logic [31:0]     ifid_instr
);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_hazard_stall && !pc_sel) |=> (pc == $past(pc) + 4));

  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |=> (pc == $past(br_target)));

  p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |=> (!ifid_valid && ifid_instr == 32'h0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_hazard_stall |=> (pc == $past(pc) && ifid_valid == $past(ifid_valid)));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_hazard_stall |-> (!pc_sel && !ifid_flush));

  p_dead_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_valid |-> !ifid_flush);

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |=> !ifid_flush);

endmodule

bind id_branch_resolver id_branch_resolver_chk #(.XLEN(XLEN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .id_hazard_stall (id_hazard_stall),
  .pc              (pc),
  .pc_sel          (pc_sel),
  .br_target       (br_target),
  .ifid_flush      (ifid_flush),
  .ifid_valid      (ifid_valid),
  .ifid_instr      (ifid_instr)
);

// File: tb/id_branch_resolver_bench.sv
module id_branch_resolver_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] if_instr;
  logic        id_is_branch;
  logic [31:0] id_opa, id_opb;
  logic [15:0] id_offset;
  logic        id_hazard_stall;
  logic [31:0] pc, br_target, ifid_instr, ifid_pc;
  logic        pc_sel, ifid_flush, ifid_valid;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [31:0] pc;
    logic        valid;
    logic [31:0] instr;
    logic [31:0] ipc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  logic [31:0] m_pc, m_ipc, m_ii;
  logic        m_iv;

  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[15:0], a[15:0]} | 32'h1;
  endfunction

  assign if_instr = mem_word(pc);

  id_branch_resolver u_id_branch_resolver (
    .clk (clk), .rst_n (rst_n), .if_instr (if_instr),
    .id_is_branch (id_is_branch), .id_opa (id_opa), .id_opb (id_opb),
    .id_offset (id_offset), .id_hazard_stall (id_hazard_stall),
    .pc (pc), .pc_sel (pc_sel), .br_target (br_target),
    .ifid_flush (ifid_flush), .ifid_valid (ifid_valid),
    .ifid_instr (ifid_instr), .ifid_pc (ifid_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of decode-side stimulus, checks the
  // combinational outputs and pushes the expected post-edge state.
  task automatic step(input logic br, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic stall, input string req);
    logic        take;
    logic [31:0] tgt;
    @(negedge clk);
    id_is_branch = br; id_opa = a; id_opb = b; id_offset = off;
    id_hazard_stall = stall;
    #1;
    take = m_iv && br && !stall && (a == b);
    tgt  = m_ipc + 32'd4 + ({{16{off[15]}}, off} << 2);
    chk(req, "pc_sel", {31'b0, pc_sel}, {31'b0, take});
    chk(req, "ifid_flush", {31'b0, ifid_flush}, {31'b0, take});
    if (take) chk("R4", "br_target", br_target, tgt);
    if (!stall) begin
      m_ipc = m_pc;
      if (take) begin
        m_pc = tgt; m_iv = 1'b0; m_ii = 32'h0;
      end else begin
        m_iv = 1'b1; m_ii = mem_word(m_pc); m_pc = m_pc + 32'd4;
      end
    end
    sb_q.push_back('{pc: m_pc, valid: m_iv, instr: m_ii, ipc: m_ipc, tag: req});
  endtask

  // Monitor: compares registered state shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "pc", pc, e.pc);
        chk(e.tag, "ifid_valid", {31'b0, ifid_valid}, {31'b0, e.valid});
        chk(e.tag, "ifid_instr", ifid_instr, e.instr);
        if (e.valid) chk(e.tag, "ifid_pc", ifid_pc, e.ipc);
      end
    end
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    id_is_branch = 1'b1; id_opa = 32'd3; id_opb = 32'd3;
    id_offset = 16'd1; id_hazard_stall = 1'b0;
    m_pc = 32'h0; m_iv = 1'b0; m_ii = 32'h0; m_ipc = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, branch inputs active but ignored
    chk("R1", "pc", pc, 32'h0);
    chk("R1", "ifid_valid", {31'b0, ifid_valid}, 32'h0);
    chk("R1", "ifid_instr", ifid_instr, 32'h0);
    chk("R1", "pc_sel", {31'b0, pc_sel}, 32'h0);
    chk("R1", "ifid_flush", {31'b0, ifid_flush}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    id_is_branch = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "pc held through sync", pc, 32'h0);

    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R2");
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R2");
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R2");
    step(1'b1, 32'd5, 32'd6, 16'd3, 1'b0, "R6");          // not taken
    step(1'b1, 32'd7, 32'd7, 16'd5, 1'b0, "R5");          // taken, forward
    step(1'b1, 32'd1, 32'd1, 16'd9, 1'b0, "R8");          // flag on a bubble
    step(1'b1, 32'd9, 32'd9, 16'hFFFE, 1'b1, "R7");       // operand pending
    step(1'b1, 32'd9, 32'd9, 16'hFFFE, 1'b1, "R7");
    step(1'b1, 32'd9, 32'd9, 16'hFFFE, 1'b0, "R9");       // release and resolve
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R5");
    step(1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 16'hFFFF, 1'b0, "R3");
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R2");
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b1, "R7");          // stall, no branch
    step(1'b1, 32'h80000000, 32'h0, 16'd4, 1'b0, "R3");   // top bit differs
    step(1'b1, 32'h12345678, 32'h12345678, 16'h8000, 1'b0, "R4"); // most negative
    step(1'b0, 32'd0, 32'd0, 16'd0, 1'b0, "R2");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule